// File: doc/BRIEF.md
# Raster point-list pixel matcher

This block lays a stored list of points over a raster video stream. Each point is held as a column and a row in two small on-chip memories, one per axis, that share one list index. A video timing source supplies the beam column, the beam row, a visible-area flag and a frame-start pulse. The block outputs a pixel-on flag and a pixel colour. When the beam sits exactly on the pending list entry, the pixel is green. Otherwise the background colour passes through.

The list must be sorted in raster order, row first and then column. The block does not scan the whole list on every clock. It holds the pending entry until the beam reaches it, and steps to the next entry only after a hit. The memories take a cycle to read. To cover this, a two-slot prefetch queue keeps the following entry ready, so a run of adjacent pixels on one row lights on consecutive clocks. A simple write port loads the list, and a count input says how many entries are valid.

Top module: `raster_point_matcher`

## Requirements
- R1: When the registered beam position equals the pending entry in both column and row while visible is high, pix_on is 1 and pix_rgb is 24'h00FF00 two clock edges after the beam inputs are presented.
- R2: A pixel whose column or row alone equals a listed point, but not both, does not light.
- R3: Any pixel that does not light gives pix_on 0, and pix_rgb equals the bg_rgb presented with it, two edges earlier.
- R4: Entries are consumed strictly in list order. An entry that lies earlier in raster order than the pending entry is never plotted in that frame.
- R5: Listed points at consecutive columns of one row all light on consecutive pixels.
- R6: Only entries 0 to point_count-1 are plotted. A count of 0 lights nothing.
- R7: A frame_start pulse returns the list to entry 0, so every frame plots the same points again.
- R8: While visible is low, nothing lights and the pending entry is not consumed. It still lights when it is later shown with visible high.
- R9: The prefetch read is held off in any cycle in which the write port targets the address about to be read, so the newly written value is the one used.
- R10: After synchronous reset, pix_on is 0 and pix_rgb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame, given during blanking |
| visible | input | 1 | Beam is inside the active picture |
| beam_x | input | 10 | Beam column |
| beam_y | input | 10 | Beam row |
| bg_rgb | input | 24 | Background colour of the current pixel |
| point_count | input | $clog2(DEPTH+1) | Number of valid list entries |
| wr_en | input | 1 | List write strobe |
| wr_addr | input | $clog2(DEPTH) | List index to write |
| wr_x | input | 10 | Column value to store |
| wr_y | input | 10 | Row value to store |
| pix_on | output | 1 | A listed point is being drawn |
| pix_rgb | output | 24 | Output colour: green on a hit, otherwise the background |

## Verification
The bench aims at a horizontal run of four adjacent pixels. A design that fetches only after each hit would miss every second pixel of that run. It also places points that share only a row or only a column with other entries, so a match on a single coordinate would light stray pixels. An unsorted two-entry list and a blanked presentation of a pending point check that entries are neither skipped nor consumed out of turn. The bench also holds a write on address 0 across the frame start. Without the read guard, the stale point would be plotted instead of the new one.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int COORD_W = 10;
    localparam int RGB_W   = 24;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [RGB_W-1:0]   rgb_t;

    localparam rgb_t HIT_COLOUR = 24'h00FF00;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } point_t;

    typedef struct packed {
        logic   vis;
        point_t beam;
        rgb_t   bg;
    } stage_t;

    function automatic logic same_spot(input point_t a, input point_t b);
        return (a.x == b.x) && (a.y == b.y);
    endfunction

endpackage

// File: rtl/pm_axis_mem.sv
module pm_axis_mem
    import pm_pkg::*;
#(
    parameter int DEPTH = 800,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  coord_t        wd,
    input  logic          re,
    input  logic [IW-1:0] ra,
    output coord_t        rq
);

    coord_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[wa] <= wd;
    end

    always_ff @(posedge clk) begin
        if (re) rq <= store[ra];
    end

    // Reading an address while it is being written is not allowed.
    assert_no_same_addr_R9: assert property (@(posedge clk) disable iff (rst)
        re |-> !(we && (wa == ra)));

endmodule

// File: rtl/pm_point_fifo.sv
module pm_point_fifo
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       push,
    input  point_t     push_pt,
    input  logic       pop,
    output point_t     head,
    output logic       head_valid,
    output logic [1:0] cnt
);

    point_t slot0, slot1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt   <= 2'd0;
            slot0 <= '0;
            slot1 <= '0;
        end else begin
            unique case ({push, pop})
                2'b11: begin
                    if (cnt == 2'd2) begin
                        slot0 <= slot1;
                        slot1 <= push_pt;
                    end else begin
                        slot0 <= push_pt;
                    end
                end
                2'b01: begin
                    slot0 <= slot1;
                    cnt   <= cnt - 2'd1;
                end
                2'b10: begin
                    if (cnt == 2'd0) slot0 <= push_pt;
                    else             slot1 <= push_pt;
                    cnt <= cnt + 2'd1;
                end
                default: ;
            endcase
        end
    end

    assign head       = slot0;
    assign head_valid = (cnt != 2'd0);

    assert_pop_needs_entry_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != 2'd0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst || clear)
        (push && !pop) |-> (cnt != 2'd2));

endmodule

// File: rtl/pm_fetch_ctrl.sv
module pm_fetch_ctrl #(
    parameter int DEPTH = 800,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic [CW-1:0] point_count,
    input  logic [1:0]    fifo_cnt,
    input  logic          pop,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    output logic          rd_en,
    output logic [IW-1:0] rd_addr,
    output logic          land
);

    logic [IW-1:0] fetch_idx;
    logic [CW-1:0] fetched_n;
    logic          inflight;
    logic [2:0]    occ;
    logic          more, room, clash;

    assign occ   = {1'b0, fifo_cnt} + {2'b0, inflight} - {2'b0, pop};
    assign more  = (fetched_n < point_count);
    assign room  = (occ < 3'd2);
    assign clash = wr_en && (wr_addr == fetch_idx);
    assign rd_en = !frame_start && more && room && !clash;
    assign rd_addr = fetch_idx;
    assign land  = inflight;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            fetch_idx <= '0;
            fetched_n <= '0;
            inflight  <= 1'b0;
        end else begin
            inflight <= rd_en;
            if (rd_en) begin
                fetched_n <= fetched_n + 1'b1;
                if (fetch_idx == IW'(DEPTH - 1)) fetch_idx <= '0;
                else                             fetch_idx <= fetch_idx + 1'b1;
            end
        end
    end

    assert_fetch_within_count_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (fetched_n < point_count));

endmodule

// File: rtl/pm_match_out.sv
module pm_match_out
    import pm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   visible,
    input  point_t beam,
    input  rgb_t   bg,
    input  point_t head,
    input  logic   head_valid,
    output logic   hit,
    output logic   pix_on,
    output rgb_t   pix_rgb
);

    stage_t s1;

    assign hit = s1.vis && head_valid && same_spot(s1.beam, head);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            pix_on  <= 1'b0;
            pix_rgb <= '0;
        end else begin
            s1      <= '{vis: visible, beam: beam, bg: bg};
            pix_on  <= hit;
            pix_rgb <= hit ? HIT_COLOUR : s1.bg;
        end
    end

    assert_hit_is_green_R1: assert property (@(posedge clk) disable iff (rst)
        pix_on |-> (pix_rgb == HIT_COLOUR));

    assert_hit_only_visible_R8: assert property (@(posedge clk) disable iff (rst)
        pix_on |-> $past(visible, 2));

endmodule

// File: rtl/raster_point_matcher.sv
module raster_point_matcher
    import pm_pkg::*;
#(
    parameter int DEPTH = 800,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                visible,
    input  logic [COORD_W-1:0]  beam_x,
    input  logic [COORD_W-1:0]  beam_y,
    input  logic [RGB_W-1:0]    bg_rgb,
    input  logic [CW-1:0]       point_count,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_addr,
    input  logic [COORD_W-1:0]  wr_x,
    input  logic [COORD_W-1:0]  wr_y,
    output logic                pix_on,
    output logic [RGB_W-1:0]    pix_rgb
);

    coord_t        wd_ax [2];
    coord_t        rq_ax [2];
    logic          rd_en, land, hit, head_valid;
    logic [IW-1:0] rd_addr;
    logic [1:0]    fifo_cnt;
    point_t        head, land_pt, beam_pt;

    assign wd_ax[0] = wr_x;
    assign wd_ax[1] = wr_y;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        pm_axis_mem #(.DEPTH(DEPTH)) u_mem (
            .clk (clk),
            .rst (rst),
            .we  (wr_en),
            .wa  (wr_addr),
            .wd  (wd_ax[a]),
            .re  (rd_en),
            .ra  (rd_addr),
            .rq  (rq_ax[a])
        );
    end

    assign land_pt = '{x: rq_ax[0], y: rq_ax[1]};
    assign beam_pt = '{x: beam_x, y: beam_y};

    pm_fetch_ctrl #(.DEPTH(DEPTH)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .point_count (point_count),
        .fifo_cnt    (fifo_cnt),
        .pop         (hit),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .land        (land)
    );

    pm_point_fifo u_fifo (
        .clk        (clk),
        .rst        (rst),
        .clear      (frame_start),
        .push       (land),
        .push_pt    (land_pt),
        .pop        (hit),
        .head       (head),
        .head_valid (head_valid),
        .cnt        (fifo_cnt)
    );

    pm_match_out u_match (
        .clk        (clk),
        .rst        (rst),
        .visible    (visible),
        .beam       (beam_pt),
        .bg         (bg_rgb),
        .head       (head),
        .head_valid (head_valid),
        .hit        (hit),
        .pix_on     (pix_on),
        .pix_rgb    (pix_rgb)
    );

endmodule

// File: tb/raster_point_matcher_test.sv
module raster_point_matcher_test;

    localparam int DEPTH = 64;
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int W = 16;
    localparam int H = 10;
    localparam int NPTS = 12;
    localparam logic [23:0] GREEN = 24'h00FF00;

    // sorted list: isolated, diagonal, horizontal run, row edges, isolated
    localparam int PTS [NPTS][2] = '{
        '{15, 0}, '{1, 1}, '{2, 2}, '{3, 3}, '{5, 4}, '{6, 4},
        '{7, 4}, '{8, 4}, '{0, 6}, '{15, 6}, '{4, 8}, '{9, 9}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic visible = 1'b0;
    logic [9:0] beam_x = '0, beam_y = '0;
    logic [23:0] bg_rgb = '0;
    logic [CW-1:0] point_count = '0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [9:0] wr_x = '0, wr_y = '0;
    logic pix_on;
    logic [23:0] pix_rgb;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int ref_x [16];
    int ref_y [16];
    int ref_n = 0;

    logic p1_chk = 0, p2_chk = 0;
    logic p1_on = 0, p2_on = 0;
    logic [23:0] p1_rgb = '0, p2_rgb = '0;
    string p1_tag = "", p2_tag = "";

    always #5 clk = ~clk;

    raster_point_matcher #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .visible(visible),
        .beam_x(beam_x), .beam_y(beam_y), .bg_rgb(bg_rgb),
        .point_count(point_count), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_x(wr_x), .wr_y(wr_y), .pix_on(pix_on), .pix_rgb(pix_rgb));

    function automatic logic [23:0] bg_of(int x, int y);
        return {8'h20, 8'(x), 8'(y)};
    endfunction

    function automatic logic listed(int x, int y);
        for (int i = 0; i < ref_n; i++)
            if (ref_x[i] == x && ref_y[i] == y) return 1'b1;
        return 1'b0;
    endfunction

    // one pixel clock: check the result of two steps ago, then drive
    task automatic step(input logic fs, input logic vis, input int x, input int y,
                        input logic chk, input logic eon, input string tag);
        @(negedge clk);
        if (p2_chk) begin
            total++;
            if (pix_on !== p2_on || pix_rgb !== p2_rgb) begin
                bad++;
                $display("FAIL %s: pix_on=%0b rgb=%h expected pix_on=%0b rgb=%h",
                         p2_tag, pix_on, pix_rgb, p2_on, p2_rgb);
            end
        end
        p2_chk = p1_chk; p2_on = p1_on; p2_rgb = p1_rgb; p2_tag = p1_tag;
        p1_chk = chk; p1_on = eon; p1_rgb = eon ? GREEN : bg_of(x, y); p1_tag = tag;
        frame_start = fs;
        visible = vis;
        beam_x = 10'(x);
        beam_y = 10'(y);
        bg_rgb = bg_of(x, y);
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) step(0, 0, W, 0, 1, 0, "R3 R8 blank");
    endtask

    task automatic rows();
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (listed(x, y)) step(0, 1, x, y, 1, 1, "R1 R5 R7 lit");
                else              step(0, 1, x, y, 1, 0, "R2 R3 R6 dark");
            end
            blank(2);
        end
    endtask

    task automatic frame();
        step(1, 0, W, 0, 1, 0, "R7 vsync");
        blank(3);
        rows();
    endtask

    task automatic write_pt(input int a, input int x, input int y);
        wr_en = 1'b1; wr_addr = IW'(a); wr_x = 10'(x); wr_y = 10'(y);
        step(0, 0, W, 0, 0, 0, "load");
        wr_en = 1'b0;
    endtask

    task automatic use_table(input int n);
        ref_n = n;
        for (int i = 0; i < n; i++) begin
            ref_x[i] = PTS[i][0];
            ref_y[i] = PTS[i][1];
        end
        point_count = CW'(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        total++;
        if (pix_on !== 1'b0 || pix_rgb !== 24'h0) begin
            bad++;
            $display("FAIL R10: pix_on=%0b rgb=%h expected pix_on=0 rgb=000000", pix_on, pix_rgb);
        end
        rst = 1'b0;

        // load the vector table with one loop
        for (int i = 0; i < NPTS; i++) write_pt(i, PTS[i][0], PTS[i][1]);

        // R1 R2 R3 R5 R7: full list, two frames in a row
        use_table(NPTS);
        frame();
        frame();

        // R6: partial count, then empty list
        use_table(5);
        frame();
        use_table(0);
        frame();

        // R8: pending entry shown blanked first, then visible
        use_table(NPTS);
        step(1, 0, W, 0, 1, 0, "R7 vsync");
        blank(3);
        step(0, 0, 15, 0, 1, 0, "R8 blanked pending point");
        step(0, 1, 15, 0, 1, 1, "R8 pending point still lights");
        step(0, 1, 1, 1, 1, 1, "R8 next entry follows");
        blank(3);

        // R4: unsorted list, entry 1 lies behind entry 0
        write_pt(0, 5, 2);
        write_pt(1, 1, 1);
        point_count = CW'(2);
        ref_n = 1; ref_x[0] = 5; ref_y[0] = 2;
        step(1, 0, W, 0, 1, 0, "R7 vsync");
        blank(3);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (x == 5 && y == 2) step(0, 1, x, y, 1, 1, "R4 first entry");
                else                  step(0, 1, x, y, 1, 0, "R4 out of order entry");
            end
            blank(2);
        end

        // R9: write to entry 0 held across frame start
        point_count = CW'(1);
        ref_n = 1; ref_x[0] = 3; ref_y[0] = 3;
        wr_en = 1'b1; wr_addr = '0; wr_x = 10'd3; wr_y = 10'd3;
        step(1, 0, W, 0, 1, 0, "R9 vsync");
        blank(3);
        wr_en = 1'b0;
        blank(3);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (x == 3 && y == 3) step(0, 1, x, y, 1, 1, "R9 new value");
                else                  step(0, 1, x, y, 1, 0, "R9 stale value");
            end
            blank(2);
        end

        blank(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule